// File: doc/BRIEF.md
# Disk Sector Read Sequencer

This block fetches a single 512-byte sector from an ATA drive using 28-bit logical block addressing and programmed I/O. A one-cycle start pulse captures a 28-bit block address. The block then drives a simple register bus engine to do the following, in order:

- load the four address registers;
- request one sector;
- issue the read command;
- poll the status register until the drive is ready to transfer.

After that it streams 256 sixteen-bit data words into a byte-wide buffer write port.

When it finishes, the block raises a one-cycle done pulse with an 8-bit result code. The code is zero on success. On a drive error it carries the drive's error register, or 0xFF if that register reads zero. It is 0xFE when the status polls run out.

The register bus uses a request/acknowledge handshake. The sequencer holds a request with its 3-bit register address, direction and write byte until it sees a one-cycle acknowledge. Read data is valid in the acknowledge cycle. The drive decodes the register addresses as follows: 0 data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 command (write) / status (read).

Top module: `ata_sector_reader`

## Requirements
- R1: The first bus access after an accepted start writes register 6 with 0xE0 ORed with address bits 27..24.
- R2: The address registers are written in this order: register 6, then register 5 (address bits 23..16), then register 4 (bits 15..8), then register 3 (bits 7..0).
- R3: After the address, register 2 is written with 1, and then register 7 is written with the read command 0x20.
- R4: Status (register 7, read) is re-read until bit 7 (busy) is 0 and bit 3 (data request) is 1; each read that fails this costs exactly one more status read.
- R5: If status bit 0 (error) is 1 when the drive becomes ready, register 1 is read once, no buffer write occurs, and the result is that register's low byte, or 0xFF if it is zero.
- R6: On a ready status without error, register 0 is read 256 times. Each word is written to the buffer as the low byte and then the high byte, at byte addresses 0 to 511 in sequence, with one write-enable cycle per byte.
- R7: A successful transfer ends with result 0x00.
- R8: After POLL_LIMIT status reads that are not ready, the sequence ends with result 0xFE and no further bus access.
- R9: Busy is high from the cycle after an accepted start until done. A start while busy is ignored, and it produces no extra bus access.
- R10: Done is a single-cycle pulse, and busy is low in the following cycle.
- R11: A bus request keeps its address, direction and write data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to read a sector |
| lba | input | 28 | Block address, captured on an accepted start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Result code, valid with done and held afterwards |
| busReq | output | 1 | Register bus request |
| busWrite | output | 1 | 1 = register write, 0 = register read |
| busAddr | output | 3 | Drive register address |
| busWdata | output | 8 | Register write byte |
| busAck | input | 1 | One-cycle acknowledge from the bus engine |
| busRdata | input | 16 | Register read data, valid with busAck |
| bufWe | output | 1 | Buffer byte write enable |
| bufAddr | output | 9 | Buffer byte address |
| bufData | output | 8 | Buffer write byte |

## Verification
Drive models are tried in five scenarios:

- an instantly ready drive;
- a drive that first reports busy and then a missing data request, which shows that each condition independently holds off the transfer;
- an error with a nonzero error code;
- an error whose code reads zero, which separates a pass-through code from the forced 0xFF;
- a drive that never becomes ready, which exposes the poll limit.

Two block addresses with different top nibbles and byte values, together with differing data seeds, separate the register ordering and byte lane order. A start pulsed during a transfer must leave the expected bus write stream untouched.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_ERROR  = 3'd1;
  localparam logic [2:0] REG_SECCNT = 3'd2;
  localparam logic [2:0] REG_SECTOR = 3'd3;
  localparam logic [2:0] REG_CYLLO  = 3'd4;
  localparam logic [2:0] REG_CYLHI  = 3'd5;
  localparam logic [2:0] REG_HEAD   = 3'd6;
  localparam logic [2:0] REG_CMD    = 3'd7;

  localparam logic [7:0] CMD_READ    = 8'h20;
  localparam logic [7:0] RES_TIMEOUT = 8'hFE;
  localparam logic [7:0] RES_ZEROERR = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HEAD, ST_CYLHI, ST_CYLLO, ST_SECT, ST_COUNT, ST_CMD,
    ST_POLL, ST_ERRRD, ST_DATARD, ST_LOBYTE, ST_HIBYTE, ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic loadLba;
    logic pollInc;
    logic wordCap;
    logic byteInc;
    logic resOk;
    logic resTimeout;
    logic resErr;
  } seqStrobe_t;

endpackage

// File: rtl/ata_seq_dpath.sv
module ata_seq_dpath
  import ata_seq_pkg::*;
#(
  parameter int POLL_LIMIT = 16,
  parameter int BYTE_AW    = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic               byteHi,
  input  logic [27:0]        lbaIn,
  input  logic [2:0]         busAddr,
  input  logic [15:0]        busRdata,
  output logic [7:0]         busWdata,
  output logic               pollExpired,
  output logic               lastByte,
  output logic [BYTE_AW-1:0] bufAddr,
  output logic [7:0]         bufData,
  output logic [7:0]         result
);

  localparam int PW = $clog2(POLL_LIMIT + 1);

  logic [27:0]        lbaQ;
  logic [PW-1:0]      pollCnt;
  logic [15:0]        wordQ;
  logic [BYTE_AW-1:0] byteCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lbaQ    <= '0;
      pollCnt <= '0;
      wordQ   <= '0;
      byteCnt <= '0;
      result  <= '0;
    end else begin
      if (stb.loadLba) begin
        lbaQ    <= lbaIn;
        pollCnt <= '0;
        byteCnt <= '0;
      end
      if (stb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (stb.wordCap) wordQ <= busRdata;
      if (stb.byteInc) byteCnt <= byteCnt + 1'b1;
      if (stb.resOk) result <= 8'h00;
      if (stb.resTimeout) result <= RES_TIMEOUT;
      if (stb.resErr) result <= (busRdata[7:0] == 8'h00) ? RES_ZEROERR : busRdata[7:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      REG_HEAD:   busWdata = {4'hE, lbaQ[27:24]};
      REG_CYLHI:  busWdata = lbaQ[23:16];
      REG_CYLLO:  busWdata = lbaQ[15:8];
      REG_SECTOR: busWdata = lbaQ[7:0];
      REG_SECCNT: busWdata = 8'h01;
      REG_CMD:    busWdata = CMD_READ;
      default:    busWdata = 8'h00;
    endcase
  end

  assign pollExpired = (pollCnt == PW'(POLL_LIMIT - 1));
  assign lastByte    = &byteCnt;
  assign bufAddr     = byteCnt;
  assign bufData     = byteHi ? wordQ[15:8] : wordQ[7:0];

endmodule

// File: rtl/ata_seq_ctrl.sv
module ata_seq_ctrl
  import ata_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       busAck,
  input  logic       statBsy,
  input  logic       statDrq,
  input  logic       statErr,
  input  logic       pollExpired,
  input  logic       lastByte,
  output seqStrobe_t stb,
  output logic       busReq,
  output logic       busWrite,
  output logic [2:0] busAddr,
  output logic       bufWe,
  output logic       byteHi,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    busReq    = 1'b0;
    busWrite  = 1'b0;
    busAddr   = REG_DATA;
    bufWe     = 1'b0;
    byteHi    = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.loadLba = 1'b1;
        nextState   = ST_HEAD;
      end
      ST_HEAD:  begin busReq = 1'b1; busWrite = 1'b1; busAddr = REG_HEAD;   if (busAck) nextState = ST_CYLHI; end
      ST_CYLHI: begin busReq = 1'b1; busWrite = 1'b1; busAddr = REG_CYLHI;  if (busAck) nextState = ST_CYLLO; end
      ST_CYLLO: begin busReq = 1'b1; busWrite = 1'b1; busAddr = REG_CYLLO;  if (busAck) nextState = ST_SECT;  end
      ST_SECT:  begin busReq = 1'b1; busWrite = 1'b1; busAddr = REG_SECTOR; if (busAck) nextState = ST_COUNT; end
      ST_COUNT: begin busReq = 1'b1; busWrite = 1'b1; busAddr = REG_SECCNT; if (busAck) nextState = ST_CMD;   end
      ST_CMD:   begin busReq = 1'b1; busWrite = 1'b1; busAddr = REG_CMD;    if (busAck) nextState = ST_POLL;  end
      ST_POLL: begin
        busReq  = 1'b1;
        busAddr = REG_CMD;
        if (busAck) begin
          if (!statBsy && statDrq) begin
            nextState = statErr ? ST_ERRRD : ST_DATARD;
          end else if (pollExpired) begin
            stb.resTimeout = 1'b1;
            nextState      = ST_FINISH;
          end else begin
            stb.pollInc = 1'b1;
          end
        end
      end
      ST_ERRRD: begin
        busReq  = 1'b1;
        busAddr = REG_ERROR;
        if (busAck) begin
          stb.resErr = 1'b1;
          nextState  = ST_FINISH;
        end
      end
      ST_DATARD: begin
        busReq = 1'b1;
        if (busAck) begin
          stb.wordCap = 1'b1;
          nextState   = ST_LOBYTE;
        end
      end
      ST_LOBYTE: begin
        bufWe       = 1'b1;
        stb.byteInc = 1'b1;
        nextState   = ST_HIBYTE;
      end
      ST_HIBYTE: begin
        bufWe       = 1'b1;
        byteHi      = 1'b1;
        stb.byteInc = 1'b1;
        if (lastByte) begin
          stb.resOk = 1'b1;
          nextState = ST_FINISH;
        end else begin
          nextState = ST_DATARD;
        end
      end
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

endmodule

// File: rtl/ata_sector_reader.sv
module ata_sector_reader
  import ata_seq_pkg::*;
#(
  parameter int POLL_LIMIT   = 16,
  parameter int SECTOR_WORDS = 256,
  localparam int BYTE_AW     = $clog2(2 * SECTOR_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [27:0]        lba,
  output logic               busy,
  output logic               done,
  output logic [7:0]         result,
  output logic               busReq,
  output logic               busWrite,
  output logic [2:0]         busAddr,
  output logic [7:0]         busWdata,
  input  logic               busAck,
  input  logic [15:0]        busRdata,
  output logic               bufWe,
  output logic [BYTE_AW-1:0] bufAddr,
  output logic [7:0]         bufData
);

  seqStrobe_t stb;
  logic       byteHi;
  logic       pollExpired;
  logic       lastByte;

  ata_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .busAck      (busAck),
    .statBsy     (busRdata[7]),
    .statDrq     (busRdata[3]),
    .statErr     (busRdata[0]),
    .pollExpired (pollExpired),
    .lastByte    (lastByte),
    .stb         (stb),
    .busReq      (busReq),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .bufWe       (bufWe),
    .byteHi      (byteHi),
    .busy        (busy),
    .done        (done)
  );

  ata_seq_dpath #(.POLL_LIMIT(POLL_LIMIT), .BYTE_AW(BYTE_AW)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .byteHi      (byteHi),
    .lbaIn       (lba),
    .busAddr     (busAddr),
    .busRdata    (busRdata),
    .busWdata    (busWdata),
    .pollExpired (pollExpired),
    .lastByte    (lastByte),
    .bufAddr     (bufAddr),
    .bufData     (bufData),
    .result      (result)
  );

endmodule

// File: rtl/ata_sector_reader_chk.sv
module ata_sector_reader_chk #(
  parameter int BYTE_AW = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               busReq,
  input logic               busWrite,
  input logic [2:0]         busAddr,
  input logic [7:0]         busWdata,
  input logic               busAck,
  input logic               bufWe,
  input logic [BYTE_AW-1:0] bufAddr
);

  AST_HEAD_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == 3'd6) |-> (busWdata[7:4] == 4'hE)); // R1

  AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busAddr == 3'd7) |-> (busWdata == 8'h20)); // R3

  AST_LOW_BYTE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufWe) |-> (bufAddr[0] == 1'b0)); // R6

  AST_NO_BUS_DURING_STORE: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> !busReq); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !bufWe && !done)); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWrite) && $stable(busWdata))); // R11

endmodule

bind ata_sector_reader ata_sector_reader_chk #(.BYTE_AW(BYTE_AW)) u_chk (.*);

// File: tb/tb_ata_sector_reader.sv
module tb_ata_sector_reader;

  localparam int POLLS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [27:0] lba = '0;
  logic        busy, done, busReq, busWrite, bufWe;
  logic [7:0]  result, busWdata, bufData;
  logic [2:0]  busAddr;
  logic [8:0]  bufAddr;
  logic        busAck = 1'b0;
  logic [15:0] busRdata = '0;

  always #5 clk = ~clk;

  ata_sector_reader #(.POLL_LIMIT(POLLS)) dut (.*);

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // drive model settings
  int          notReady = 0;
  logic        errBit = 1'b0;
  logic [7:0]  errVal = 8'h00;
  logic [15:0] seed = 16'h0000;
  int          statusReads = 0;
  int          errReads = 0;
  int          wordIdx = 0;

  logic [10:0] expW[$];
  logic [16:0] expB[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] patWord(input int i, input logic [15:0] s);
    return {s[15:8] + 8'(i), s[7:0] ^ 8'(i)};
  endfunction

  // drive register bus responder
  always @(posedge clk) begin
    if (busReq && !busAck) begin
      busAck <= 1'b1;
      if (!busWrite) begin
        case (busAddr)
          3'd7: begin
            statusReads <= statusReads + 1;
            if (notReady > 0) begin
              notReady <= notReady - 1;
              busRdata <= (notReady % 2 == 1) ? 16'h00C8 : 16'h0040;
            end else begin
              busRdata <= {8'h00, 7'b0100100, errBit};
            end
          end
          3'd1: begin errReads <= errReads + 1; busRdata <= {8'hAA, errVal}; end
          3'd0: begin wordIdx <= wordIdx + 1; busRdata <= patWord(wordIdx, seed); end
          default: busRdata <= 16'hDEAD;
        endcase
      end
    end else begin
      busAck <= 1'b0;
    end
  end

  // monitor: bus writes and buffer bytes
  always @(negedge clk) begin
    if (rstN && busReq && busWrite && busAck) begin
      if (expW.size() == 0) check(0, "R2", "unexpected bus write", {busAddr, busWdata}, 0);
      else begin
        logic [10:0] e;
        e = expW.pop_front();
        check({busAddr, busWdata} == e, "R3", "bus write addr/data", {busAddr, busWdata}, e);
      end
    end
    if (rstN && bufWe) begin
      if (expB.size() == 0) check(0, "R5", "unexpected buffer write", {bufAddr, bufData}, 0);
      else begin
        logic [16:0] e;
        e = expB.pop_front();
        check({bufAddr, bufData} == e, "R6", "buffer addr/data", {bufAddr, bufData}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic runRead(input logic [27:0] a, input int nr, input logic eb,
                         input logic [7:0] ev, input logic [15:0] sd,
                         input bit midStart, input string req);
    logic [7:0] expRes;
    int expPolls;
    bit ok;
    notReady = nr; errBit = eb; errVal = ev; seed = sd;
    statusReads = 0; errReads = 0; wordIdx = 0;
    expW.push_back({3'd6, 4'hE, a[27:24]});   // R1
    expW.push_back({3'd5, a[23:16]});         // R2
    expW.push_back({3'd4, a[15:8]});
    expW.push_back({3'd3, a[7:0]});
    expW.push_back({3'd2, 8'h01});            // R3
    expW.push_back({3'd7, 8'h20});
    if (nr >= POLLS) begin
      expRes = 8'hFE; expPolls = POLLS;
    end else if (eb) begin
      expRes = (ev == 0) ? 8'hFF : ev; expPolls = nr + 1;
    end else begin
      expRes = 8'h00; expPolls = nr + 1;
      for (int i = 0; i < 256; i++) begin
        logic [15:0] w;
        w = patWord(i, sd);
        expB.push_back({9'(2 * i), w[7:0]});
        expB.push_back({9'(2 * i + 1), w[15:8]});
      end
    end
    @(negedge clk); lba = a; start = 1'b1;
    @(negedge clk); start = 1'b0; lba = ~a;
    check(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (midStart) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    ok = 0;
    for (int k = 0; k < 5000 && !ok; k++) begin
      if (done) ok = 1; else @(negedge clk);
    end
    check(ok, req, "done seen", ok, 1);
    check(result == expRes, req, "result code", result, expRes);
    check(statusReads == expPolls, "R4", "status reads", statusReads, expPolls);
    check(errReads == ((eb && nr < POLLS) ? 1 : 0), "R5", "error reads", errReads, (eb && nr < POLLS) ? 1 : 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "done single pulse", {done, busy}, 0);
    repeat (5) @(negedge clk);
    check(busy == 1'b0, "R9", "stays idle", busy, 0);
    check(expW.size() == 0, "R2", "pending bus writes", expW.size(), 0);
    check(expB.size() == 0, "R6", "pending buffer bytes", expB.size(), 0);
    expW.delete(); expB.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && busReq == 0 && bufWe == 0, "R9", "reset state",
          {busy, done, busReq, bufWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runRead(28'h1234567, 3, 1'b0, 8'h00, 16'h5A3C, 1'b0, "R7");   // busy then no-DRQ waits
    runRead(28'hFABCDEF, 0, 1'b0, 8'h00, 16'hC3A5, 1'b1, "R7");   // ready at once, start ignored R9
    runRead(28'h0000001, 2, 1'b1, 8'h04, 16'h0000, 1'b0, "R5");   // drive error code
    runRead(28'h8765432, 0, 1'b1, 8'h00, 16'h0000, 1'b0, "R5");   // zero error code -> FF
    runRead(28'h3F0F0F0, 1000, 1'b0, 8'h00, 16'h0000, 1'b0, "R8"); // never ready
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule